// File: doc/BRIEF.md
# SAR ADC Conversion Readout Controller

The block runs one conversion and one readback of a serial successive-approximation ADC for each trigger. A trigger starts a conversion on the converter, and the block waits out the conversion time. It then clocks the result in most-significant bit first over an SPI mode 0 link. At the end it presents the result as a parallel, extended word with a one-cycle valid pulse. All waits are cycle counts that the block derives from a clock-frequency parameter, rounded up to whole cycles.

Two wiring schemes are selected per request through the `three_wire` input.
- **Four-wire:** a dedicated convert line is held high through conversion and readout. The chip-select line, which also drives the converter's data-in pin, goes low only when the conversion time has passed.
- **Three-wire:** chip-select is itself the convert strobe, and data-in stays high. The block first pulses chip-select to start a conversion belonging to this request, then asserts chip-select again for the readout, and then keeps a quiet gap before it accepts the next request.

The `turbo` input shortens the conversion wait. Parameters fix the result width (16, 18 or 20 bits) and whether codes are two's complement or straight binary.

Top module: `sar_readout_ctrl`

## Requirements
- R1: After reset, and whenever idle, the outputs are as follows: `adc_cs_n`=1, `adc_cnv`=0, `adc_sck`=0, `adc_sdi`=1, `busy`=0, `smp_valid`=0, `overrun`=0 and `smp_data`=0.
- R2: In four-wire mode (`three_wire`=0 at the trigger), the following hold:
  - `adc_cnv` rises one cycle after the trigger and stays high until readout ends.
  - `adc_cs_n` falls exactly N cycles after `adc_cnv` rises. N = ceil(320 ns × f) with `turbo`=0 and ceil(190 ns × f) with `turbo`=1. At 100 MHz, N is 32 or 19.
  - `adc_sdi` follows `adc_cs_n`.
- R3: In three-wire mode, the following hold:
  - `adc_cnv` stays low.
  - `adc_cs_n` goes low for one cycle, then high for N cycles (N as in R2), then low for the readout.
  - The returned sample is the one converted at that request's chip-select rising edge, not the previous request's.
- R4: In three-wire mode, `busy` stays high for exactly ceil(60 ns × f) cycles, counting from the cycle of `smp_valid` (6 at 100 MHz). In four-wire mode, `busy` is low in the cycle of `smp_valid`.
- R5: In three-wire mode, `adc_sdi` is 1 throughout the request.
- R6: Readout follows SPI mode 0. `adc_sck` is low whenever `adc_cs_n` is high, the input is sampled on `adc_sck` rising edges, and bits arrive MSB first. There are 16 rising edges per readout for a 16-bit result and 32 for 18- or 20-bit results.
- R7: A result wider than 16 bits is taken left-justified from the 32-bit frame: 18-bit from frame bits 31..14, 20-bit from bits 31..12. A 16-bit result is the whole 16-bit frame.
- R8: `smp_data` is the result sign-extended to `OUT_W` bits when `SIGNED`=1, and zero-extended when `SIGNED`=0.
- R9: Each accepted trigger yields exactly one single-cycle `smp_valid` pulse, with `smp_data` valid in that cycle and held afterwards.
- R10: A trigger while `busy`=1 is ignored: it produces no extra conversion and no extra `smp_valid`. It also sets `overrun`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| trig | input | 1 | Request one conversion and readback |
| three_wire | input | 1 | Wiring scheme for this request: 1 = chip-select is convert strobe |
| turbo | input | 1 | Use the shorter conversion wait for this request |
| adc_sdo | input | 1 | Serial data from the converter |
| adc_cnv | output | 1 | Dedicated convert line (four-wire mode) |
| adc_cs_n | output | 1 | Active-low chip-select |
| adc_sdi | output | 1 | Converter data-in line |
| adc_sck | output | 1 | Serial clock, SPI mode 0 |
| busy | output | 1 | A request is in progress |
| smp_valid | output | 1 | One-cycle pulse: `smp_data` holds a new result |
| smp_data | output | OUT_W | Extended conversion result |
| overrun | output | 1 | Sticky: a trigger arrived while busy |

## Verification
The assertions assume that reset is applied from time zero and that `three_wire` and `turbo` only matter at the accepted trigger. They also assume that `adc_sdo` changes only away from the serial clock's rising edge, as a mode 0 converter does. The stimulus meets these conditions in the following ways:
- It changes mode and code only while idle, one cycle before a trigger.
- Its converter model shifts data on the serial clock's falling edges.
- Its converter model latches a new code only on the convert edge of the selected wiring.

The one overlapping trigger is deliberate: it checks that the design ignores the trigger and sets the sticky flag.

// File: rtl/sar_rd_pkg.sv
package sar_rd_pkg;

    // Converter timing constraints, in nanoseconds
    localparam int T_CONV_NS  = 320;
    localparam int T_TURBO_NS = 190;
    localparam int T_QUIET_NS = 60;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PULSE,
        ST_CONV,
        ST_READ,
        ST_QUIET
    } rd_state_e;

    typedef struct packed {
        logic three_wire;
        logic turbo;
    } rd_cfg_t;

    // Whole clock cycles covering a delay, rounded up
    function automatic int ns_to_cycles(input int ns, input int clk_mhz);
        return (ns * clk_mhz + 999) / 1000;
    endfunction

    // Serial frame length for a given result width
    function automatic int frame_bits(input int res_bits);
        return (res_bits > 16) ? 32 : 16;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sar_wait_timer.sv
module sar_wait_timer #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sar_frame_shifter.sv
module sar_frame_shifter #(
    parameter int FRAME = 32,
    parameter int RES   = 18,
    parameter int HALF  = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           run,
    input  logic           sdo,
    output logic           sck,
    output logic [RES-1:0] code,
    output logic           done
);

    localparam int DW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int BW = $clog2(FRAME + 1);

    logic [DW-1:0] div_q;
    logic [BW-1:0] bit_q;
    logic          sck_q;
    logic          toggle;

    assign toggle = run && (div_q == DW'(HALF - 1));
    assign done   = toggle && sck_q && (bit_q == BW'(FRAME));
    assign sck    = sck_q;

    // Clock divider and bit counter; sample on the rising half
    always_ff @(posedge clk) begin
        if (rst || !run) begin
            div_q <= '0;
            bit_q <= '0;
            sck_q <= 1'b0;
        end else if (toggle) begin
            div_q <= '0;
            sck_q <= !sck_q;
            if (!sck_q) begin
                bit_q <= bit_q + 1'b1;
            end
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    // Only the leading RES bits of the frame are kept
    always_ff @(posedge clk) begin
        if (rst) begin
            code <= '0;
        end else if (toggle && !sck_q && (bit_q < BW'(RES))) begin
            code <= {code[RES-2:0], sdo};
        end
    end

    a_r6_bit_bound: assert property (@(posedge clk) disable iff (rst)
        bit_q <= BW'(FRAME));

    a_r6_bits_monotone: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run)) |-> (bit_q >= $past(bit_q)));

endmodule

// File: rtl/sar_sample_fmt.sv
module sar_sample_fmt #(
    parameter int RES    = 18,
    parameter int OUT_W  = 32,
    parameter bit SIGNED = 1'b1
) (
    input  logic [RES-1:0]   code,
    output logic [OUT_W-1:0] sample
);

    localparam int EXT = OUT_W - RES;

    generate
        if (SIGNED) begin : g_signed
            assign sample = {{EXT{code[RES-1]}}, code};
        end else begin : g_unsigned
            assign sample = {{EXT{1'b0}}, code};
        end
    endgenerate

endmodule

// File: rtl/sar_readout_ctrl.sv
module sar_readout_ctrl
    import sar_rd_pkg::*;
#(
    parameter int CLK_MHZ  = 100,
    parameter int RES_BITS = 18,
    parameter bit SIGNED   = 1'b1,
    parameter int SCK_DIV  = 4,
    parameter int OUT_W    = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig,
    input  logic             three_wire,
    input  logic             turbo,
    input  logic             adc_sdo,
    output logic             adc_cnv,
    output logic             adc_cs_n,
    output logic             adc_sdi,
    output logic             adc_sck,
    output logic             busy,
    output logic             smp_valid,
    output logic [OUT_W-1:0] smp_data,
    output logic             overrun
);

    localparam int FRAME   = frame_bits(RES_BITS);
    localparam int HALF    = SCK_DIV / 2;
    localparam int N_CONV  = ns_to_cycles(T_CONV_NS, CLK_MHZ);
    localparam int N_TURBO = ns_to_cycles(T_TURBO_NS, CLK_MHZ);
    localparam int N_QUIET = ns_to_cycles(T_QUIET_NS, CLK_MHZ);
    localparam int N_MAX   = max3(N_CONV, N_TURBO, N_QUIET);
    localparam int TW      = $clog2(N_MAX + 1);

    rd_state_e state_q, state_d;
    rd_cfg_t   cfg_q;

    logic                tmr_load;
    logic [TW-1:0]       tmr_val;
    logic                tmr_expired;
    logic                rd_run;
    logic                rd_done;
    logic [RES_BITS-1:0] rd_code;
    logic [OUT_W-1:0]    fmt_out;

    function automatic logic [TW-1:0] conv_wait(input logic use_turbo);
        return use_turbo ? TW'(N_TURBO - 1) : TW'(N_CONV - 1);
    endfunction

    // Sequencing
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = TW'(N_QUIET - 1);
        unique case (state_q)
            ST_IDLE: begin
                if (trig) begin
                    if (three_wire) begin
                        state_d = ST_PULSE;
                    end else begin
                        state_d  = ST_CONV;
                        tmr_load = 1'b1;
                        tmr_val  = conv_wait(turbo);
                    end
                end
            end
            ST_PULSE: begin
                state_d  = ST_CONV;
                tmr_load = 1'b1;
                tmr_val  = conv_wait(cfg_q.turbo);
            end
            ST_CONV: begin
                if (tmr_expired) state_d = ST_READ;
            end
            ST_READ: begin
                if (rd_done) begin
                    if (cfg_q.three_wire) begin
                        state_d  = ST_QUIET;
                        tmr_load = 1'b1;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_QUIET: begin
                if (tmr_expired) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            cfg_q     <= '0;
            smp_valid <= 1'b0;
            smp_data  <= '0;
            overrun   <= 1'b0;
        end else begin
            state_q   <= state_d;
            smp_valid <= 1'b0;
            if (state_q == ST_IDLE && trig) begin
                cfg_q <= '{three_wire: three_wire, turbo: turbo};
            end
            if (state_q != ST_IDLE && trig) begin
                overrun <= 1'b1;
            end
            if (state_q == ST_READ && rd_done) begin
                smp_valid <= 1'b1;
                smp_data  <= fmt_out;
            end
        end
    end

    // Pin decode
    assign rd_run   = (state_q == ST_READ);
    assign busy     = (state_q != ST_IDLE);
    assign adc_cnv  = !cfg_q.three_wire && (state_q == ST_CONV || state_q == ST_READ);
    assign adc_cs_n = !(state_q == ST_READ || state_q == ST_PULSE);
    assign adc_sdi  = cfg_q.three_wire ? 1'b1 : adc_cs_n;

    sar_wait_timer #(
        .W (TW)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sar_frame_shifter #(
        .FRAME (FRAME),
        .RES   (RES_BITS),
        .HALF  (HALF)
    ) u_shift (
        .clk  (clk),
        .rst  (rst),
        .run  (rd_run),
        .sdo  (adc_sdo),
        .sck  (adc_sck),
        .code (rd_code),
        .done (rd_done)
    );

    sar_sample_fmt #(
        .RES    (RES_BITS),
        .OUT_W  (OUT_W),
        .SIGNED (SIGNED)
    ) u_fmt (
        .code   (rd_code),
        .sample (fmt_out)
    );

    // Checks
    a_r2_conv_elapsed: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_READ && $past(state_q) == ST_CONV) |-> $past(tmr_expired));

    a_r4_quiet_elapsed: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && $past(state_q) == ST_QUIET) |-> $past(tmr_expired));

    a_r6_sck_idle: assert property (@(posedge clk) disable iff (rst)
        adc_cs_n |-> !adc_sck);

    a_r9_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        smp_valid |=> !smp_valid);

    a_r9_valid_after_read: assert property (@(posedge clk) disable iff (rst)
        smp_valid |-> ($past(state_q) == ST_READ));

    a_r10_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);

    a_r10_busy_trig: assert property (@(posedge clk) disable iff (rst)
        (trig && busy) |=> overrun);

endmodule

// File: tb/sar_readout_ctrl_tb.sv
module sar_adc_model #(
    parameter int FRAME = 32,
    parameter int RES   = 18
) (
    input  logic        clk,
    input  logic        conv_src,
    input  logic        cs_n,
    input  logic        sck,
    input  logic [19:0] code20,
    output logic        sdo,
    output int          gap,
    output int          nrise
);
    logic [RES-1:0]   held = '0;
    logic [FRAME-1:0] sh   = '0;
    logic pconv = 1'b1, pcs = 1'b1, psck = 1'b0;
    int cyc = 0, t0 = 0;

    initial begin
        sdo   = 1'b0;
        gap   = 0;
        nrise = 0;
    end

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (conv_src && !pconv) begin
            held = code20[19 -: RES];
            t0   = cyc;
        end
        if (!cs_n && pcs) begin
            sh = '0;
            sh[FRAME-1 -: RES] = held;
            sdo   = sh[FRAME-1];
            gap   = cyc - t0;
            nrise = 0;
        end
        if (sck && !psck) nrise = nrise + 1;
        if (!sck && psck) begin
            sh  = sh << 1;
            sdo = sh[FRAME-1];
        end
        pconv = conv_src;
        pcs   = cs_n;
        psck  = sck;
    end
endmodule

module sar_readout_ctrl_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic trig = 1'b0, three_wire = 1'b0, turbo = 1'b0;
    logic [19:0] code20 = '0;

    logic [2:0]  sdo_w, cnv_w, cs_w, sdi_w, sck_w, busy_w, val_w, ov_w;
    logic [31:0] data_w [3];
    int gap_w [3];
    int nrise_w [3];

    int tests = 0, fails = 0;
    int nval [3];
    int qcnt [3];
    int sdi_bad [3];
    logic qrun [3];
    logic [31:0] last [3];

    localparam int FR [3] = '{32, 16, 32};
    localparam int NQ = 6;
    localparam logic [21:0] VEC [8] = '{
        22'h0ABCDE, 22'h112345, 22'h280001, 22'h37FFFF,
        22'h0FFFFF, 22'h200000, 22'h35A5A5, 22'h180000};

    always #5 clk = ~clk;

    sar_readout_ctrl #(.CLK_MHZ(100), .RES_BITS(18), .SIGNED(1'b1), .SCK_DIV(4), .OUT_W(32)) u_dut (
        .clk(clk), .rst(rst), .trig(trig), .three_wire(three_wire), .turbo(turbo),
        .adc_sdo(sdo_w[0]), .adc_cnv(cnv_w[0]), .adc_cs_n(cs_w[0]), .adc_sdi(sdi_w[0]),
        .adc_sck(sck_w[0]), .busy(busy_w[0]), .smp_valid(val_w[0]), .smp_data(data_w[0]),
        .overrun(ov_w[0]));
    sar_readout_ctrl #(.CLK_MHZ(100), .RES_BITS(16), .SIGNED(1'b0), .SCK_DIV(4), .OUT_W(32)) u_dut16 (
        .clk(clk), .rst(rst), .trig(trig), .three_wire(three_wire), .turbo(turbo),
        .adc_sdo(sdo_w[1]), .adc_cnv(cnv_w[1]), .adc_cs_n(cs_w[1]), .adc_sdi(sdi_w[1]),
        .adc_sck(sck_w[1]), .busy(busy_w[1]), .smp_valid(val_w[1]), .smp_data(data_w[1]),
        .overrun(ov_w[1]));
    sar_readout_ctrl #(.CLK_MHZ(100), .RES_BITS(20), .SIGNED(1'b1), .SCK_DIV(4), .OUT_W(32)) u_dut20 (
        .clk(clk), .rst(rst), .trig(trig), .three_wire(three_wire), .turbo(turbo),
        .adc_sdo(sdo_w[2]), .adc_cnv(cnv_w[2]), .adc_cs_n(cs_w[2]), .adc_sdi(sdi_w[2]),
        .adc_sck(sck_w[2]), .busy(busy_w[2]), .smp_valid(val_w[2]), .smp_data(data_w[2]),
        .overrun(ov_w[2]));

    sar_adc_model #(.FRAME(32), .RES(18)) u_adc0 (.clk(clk),
        .conv_src(three_wire ? cs_w[0] : cnv_w[0]), .cs_n(cs_w[0]), .sck(sck_w[0]),
        .code20(code20), .sdo(sdo_w[0]), .gap(gap_w[0]), .nrise(nrise_w[0]));
    sar_adc_model #(.FRAME(16), .RES(16)) u_adc1 (.clk(clk),
        .conv_src(three_wire ? cs_w[1] : cnv_w[1]), .cs_n(cs_w[1]), .sck(sck_w[1]),
        .code20(code20), .sdo(sdo_w[1]), .gap(gap_w[1]), .nrise(nrise_w[1]));
    sar_adc_model #(.FRAME(32), .RES(20)) u_adc2 (.clk(clk),
        .conv_src(three_wire ? cs_w[2] : cnv_w[2]), .cs_n(cs_w[2]), .sck(sck_w[2]),
        .code20(code20), .sdo(sdo_w[2]), .gap(gap_w[2]), .nrise(nrise_w[2]));

    // Output monitor, sampled away from the active edge
    initial begin
        for (int k = 0; k < 3; k++) begin
            nval[k] = 0; qcnt[k] = 0; sdi_bad[k] = 0; qrun[k] = 1'b0; last[k] = '0;
        end
    end
    always @(negedge clk) begin
        for (int k = 0; k < 3; k++) begin
            if (val_w[k]) begin
                nval[k] = nval[k] + 1;
                last[k] = data_w[k];
                qcnt[k] = busy_w[k] ? 1 : 0;
                qrun[k] = busy_w[k];
            end else if (qrun[k] && busy_w[k]) begin
                qcnt[k] = qcnt[k] + 1;
            end else begin
                qrun[k] = 1'b0;
            end
            if (!rst && busy_w[k]) begin
                if (three_wire && !sdi_w[k]) sdi_bad[k] = sdi_bad[k] + 1;
                if (!three_wire && (sdi_w[k] !== cs_w[k])) sdi_bad[k] = sdi_bad[k] + 1;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests = tests + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] expect_data(input int k, input logic [19:0] c);
        logic [17:0] c18;
        logic [15:0] c16;
        c18 = c[19:2];
        c16 = c[19:4];
        case (k)
            0:       return {{14{c18[17]}}, c18};
            1:       return {16'h0, c16};
            default: return {{12{c[19]}}, c};
        endcase
    endfunction

    task automatic wait_idle();
        int guard = 0;
        @(negedge clk);
        while ((|busy_w) && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic start(input logic m3, input logic tb, input logic [19:0] c);
        @(negedge clk);
        three_wire = m3; turbo = tb; code20 = c;
        @(negedge clk);
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
    endtask

    task automatic run_txn(input logic m3, input logic tb, input logic [19:0] c);
        int nv0 [3];
        int sb0 [3];
        int n;
        for (int k = 0; k < 3; k++) begin nv0[k] = nval[k]; sb0[k] = sdi_bad[k]; end
        start(m3, tb, c);
        wait_idle();
        n = tb ? 19 : 32;
        for (int k = 0; k < 3; k++) begin
            chk("R9 one valid per trigger", nval[k] - nv0[k], 1);
            chk("R3 R7 R8 sample value", last[k], expect_data(k, c));
            if (m3) begin
                chk("R3 conversion wait before readout", gap_w[k], n);
                chk("R5 data-in held high", sdi_bad[k] - sb0[k], 0);
                chk("R4 quiet interval", qcnt[k], NQ);
            end else begin
                chk("R2 conversion wait before chip-select", gap_w[k], n);
                chk("R2 data-in follows chip-select", sdi_bad[k] - sb0[k], 0);
                chk("R4 no quiet in four-wire", qcnt[k], 0);
            end
            chk("R6 rising edges per frame", nrise_w[k], FR[k]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails = fails + 1;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: idle levels after reset
        for (int k = 0; k < 3; k++) begin
            chk("R1 idle pins", {25'h0, cs_w[k], cnv_w[k], sck_w[k], sdi_w[k], busy_w[k], val_w[k], ov_w[k]},
                32'b1001000);
            chk("R1 idle data", data_w[k], 32'h0);
        end

        for (int v = 0; v < 8; v++) begin
            run_txn(VEC[v][21], VEC[v][20], VEC[v][19:0]);
        end
        for (int k = 0; k < 3; k++) chk("R10 no overrun without overlap", {31'h0, ov_w[k]}, 0);

        // R10: overlapping trigger during a four-wire request
        begin
            int nv0 [3];
            for (int k = 0; k < 3; k++) nv0[k] = nval[k];
            start(1'b0, 1'b0, 20'h3C3C3);
            repeat (5) @(negedge clk);
            code20 = 20'hC0FFE;
            trig = 1'b1;
            @(negedge clk);
            trig = 1'b0;
            wait_idle();
            for (int k = 0; k < 3; k++) begin
                chk("R10 ignored trigger gives one valid", nval[k] - nv0[k], 1);
                chk("R10 ignored trigger keeps first sample", last[k], expect_data(k, 20'h3C3C3));
                chk("R10 overrun set", {31'h0, ov_w[k]}, 1);
            end
        end

        run_txn(1'b1, 1'b0, 20'h6789A);
        for (int k = 0; k < 3; k++) chk("R10 overrun sticky", {31'h0, ov_w[k]}, 1);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule